// File: doc/BRIEF.md
# Two-Queue Sequencer Status and Control Registers

This block is the software-facing register set of a conversion sequencer that runs two command queues. For each queue it keeps a completion flag and a pause flag, and for each queue one trigger-overrun bit; the sequencer sets these six bits with single-cycle event pulses. Software clears a flag by first reading the status word, which arms every bit that read as one, and then writing zero to that bit. A bit that was not armed by the last read cannot be cleared, so an event that lands between the read and the write is never lost. The upper byte of the status word is a read-only view of sequencer state taken straight from an input.

Each queue also has a control word holding its operating mode, a completion interrupt enable and a pause interrupt enable. Its single-scan bit is a strobe: writing one sends a one-cycle start pulse to the sequencer, and the bit always reads back as zero. Each queue has an interrupt output, raised when a flag of that queue is set and its enable is on.

The bus is a synchronous port with separate read and write strobes. Control word q sits at address q, the status word at address NUM_Q, and every other address reads zero. Read data is registered.

Top module: `qseq_status_regs`

## Requirements
- R1: After reset all six flags, all control fields, `irq` and `scan_start` are zero, so the status word reads only the view byte.
- R2: A pulse on `ev_done[q]`, `ev_pause[q]` or `ev_trig_ovr[q]` sets status bit 2q, 2q+1 or 4+q respectively (with NUM_Q=2), and the bit stays set.
- R3: A status read arms each flag that read as one; a following status write clears an armed flag whose write-data bit is zero and leaves a flag whose write-data bit is one unchanged.
- R4: A zero written to a flag that no status read has armed leaves the flag set.
- R5: A flag that becomes one after the status read is not armed, and the next zero write leaves it set while armed flags in the same write clear.
- R6: Any status write drops every arm, so a second zero write without a new read leaves the flag set.
- R7: When a set event and a qualifying clear write reach a flag in the same cycle, the flag ends set.
- R8: Status bits 15:8 always read the current `seq_view` input and a status write does not alter them; bits 7:6 read zero.
- R9: Control word layout: bit 0 single-scan, bits 2:1 mode, bit 3 completion interrupt enable, bit 4 pause interrupt enable; mode and enables read back as written, mode appears on `q_mode`, bit 0 always reads zero.
- R10: Writing a control word with bit 0 set raises `scan_start[q]` for exactly one cycle, in the cycle after the write edge, for that queue only; writing bit 0 as zero gives no pulse.
- R11: `irq[q]` is one exactly when (completion flag q and its enable) or (pause flag q and its enable) held at the previous edge.
- R12: `bus_rdata` holds the addressed word from the edge that samples `bus_rd`; addresses above NUM_Q read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (ignored while bus_wr is high) |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| ev_done | input | NUM_Q | Per-queue completion event pulse |
| ev_pause | input | NUM_Q | Per-queue pause event pulse |
| ev_trig_ovr | input | NUM_Q | Per-queue trigger-overrun event pulse |
| seq_view | input | VIEW_W | Read-only sequencer state shown in the status word |
| q_mode | output | NUM_Q*MODE_W | Operating mode of each queue |
| scan_start | output | NUM_Q | One-cycle single-scan start pulse per queue |
| irq | output | NUM_Q | Per-queue interrupt request |

## Verification
A flag, arm or control field takes its new value at the edge that samples the event or write, and a read issued on the next cycle returns it at the edge after, so the bench samples read data on the falling edge following the read edge. `scan_start` is due on the falling edge right after the write edge and is checked again one cycle later for its fall. `irq` trails its flag by one further edge, so the bench checks it low directly after the event and high one cycle later. Same-cycle races, such as a set event together with a clearing write, are driven on one falling edge so both reach the same rising edge.

// File: rtl/qsr_pkg.sv
package qsr_pkg;
  localparam int SSE_BIT  = 0;
  localparam int MODE_LSB = 1;

  function automatic int cie_bit(input int mode_w);
    return MODE_LSB + mode_w;
  endfunction

  function automatic int pie_bit(input int mode_w);
    return MODE_LSB + mode_w + 1;
  endfunction

  function automatic int done_idx(input int q);
    return 2 * q;
  endfunction

  function automatic int pause_idx(input int q);
    return 2 * q + 1;
  endfunction

  function automatic int ovr_idx(input int num_q, input int q);
    return 2 * num_q + q;
  endfunction
endpackage

// File: rtl/qsr_flag_bit.sv
// One software-clearable status bit with its read-arm state.
module qsr_flag_bit (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic arm_ld_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic flag_o
);
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o <= 1'b0;
      armed  <= 1'b0;
    end else begin
      if (set_i)
        flag_o <= 1'b1;
      else if (wr_i && armed && !wbit_i)
        flag_o <= 1'b0;
      if (wr_i)
        armed <= 1'b0;
      else if (arm_ld_i)
        armed <= flag_o;
    end
  end
endmodule

// File: rtl/qsr_ctrl_reg.sv
// Per-queue control word: mode, interrupt enables and a single-scan strobe.
module qsr_ctrl_reg
  import qsr_pkg::*;
#(
  parameter int MODE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [MODE_W+2:0] wdata_i,
  output logic [MODE_W-1:0] mode_o,
  output logic              cie_o,
  output logic              pie_o,
  output logic              start_o,
  output logic [MODE_W+2:0] rd_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_o  <= '0;
      cie_o   <= 1'b0;
      pie_o   <= 1'b0;
      start_o <= 1'b0;
    end else begin
      start_o <= wr_i && wdata_i[SSE_BIT];
      if (wr_i) begin
        mode_o <= wdata_i[MODE_LSB +: MODE_W];
        cie_o  <= wdata_i[cie_bit(MODE_W)];
        pie_o  <= wdata_i[pie_bit(MODE_W)];
      end
    end
  end

  // Strobe bit is never stored, so it reads as zero.
  assign rd_o = {pie_o, cie_o, mode_o, 1'b0};
endmodule

// File: rtl/qsr_irq_gen.sv
// Registered per-queue interrupt request.
module qsr_irq_gen #(
  parameter int NUM_Q = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NUM_Q-1:0] done_i,
  input  logic [NUM_Q-1:0] pause_i,
  input  logic [NUM_Q-1:0] cie_i,
  input  logic [NUM_Q-1:0] pie_i,
  output logic [NUM_Q-1:0] irq_o
);
  always_ff @(posedge clk) begin
    if (rst) irq_o <= '0;
    else     irq_o <= (done_i & cie_i) | (pause_i & pie_i);
  end
endmodule

// File: rtl/qseq_status_regs.sv
module qseq_status_regs
  import qsr_pkg::*;
#(
  parameter int NUM_Q  = 2,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4,
  parameter int MODE_W = 2,
  parameter int VIEW_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [DATA_W-1:0]       bus_wdata,
  output logic [DATA_W-1:0]       bus_rdata,
  input  logic [NUM_Q-1:0]        ev_done,
  input  logic [NUM_Q-1:0]        ev_pause,
  input  logic [NUM_Q-1:0]        ev_trig_ovr,
  input  logic [VIEW_W-1:0]       seq_view,
  output logic [NUM_Q*MODE_W-1:0] q_mode,
  output logic [NUM_Q-1:0]        scan_start,
  output logic [NUM_Q-1:0]        irq
);
  localparam int NUM_FLAGS = 3 * NUM_Q;
  localparam int CTRL_W    = MODE_W + 3;
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(NUM_Q);

  logic [NUM_FLAGS-1:0] flags;
  logic [NUM_FLAGS-1:0] set_vec;
  logic [NUM_Q-1:0]     cie, pie, done_f, pause_f;
  logic [DATA_W-1:0]    ctrl_word [NUM_Q];
  logic [DATA_W-1:0]    stat_word;
  logic [DATA_W-1:0]    rd_next;
  logic                 stat_wr, stat_rd;
  logic                 unused_wdata;

  assign stat_wr      = bus_wr && (bus_addr == STAT_ADDR);
  assign stat_rd      = bus_rd && !bus_wr && (bus_addr == STAT_ADDR);
  assign unused_wdata = ^bus_wdata;

  genvar q;
  generate
    for (q = 0; q < NUM_Q; q++) begin : g_queue
      logic [CTRL_W-1:0] rd_bits;

      assign set_vec[done_idx(q)]         = ev_done[q];
      assign set_vec[pause_idx(q)]        = ev_pause[q];
      assign set_vec[ovr_idx(NUM_Q, q)]   = ev_trig_ovr[q];
      assign done_f[q]                    = flags[done_idx(q)];
      assign pause_f[q]                   = flags[pause_idx(q)];

      qsr_ctrl_reg #(.MODE_W(MODE_W)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (bus_wr && (bus_addr == ADDR_W'(q))),
        .wdata_i (bus_wdata[CTRL_W-1:0]),
        .mode_o  (q_mode[q*MODE_W +: MODE_W]),
        .cie_o   (cie[q]),
        .pie_o   (pie[q]),
        .start_o (scan_start[q]),
        .rd_o    (rd_bits)
      );

      assign ctrl_word[q] = {{(DATA_W-CTRL_W){1'b0}}, rd_bits};
    end

    for (q = 0; q < NUM_FLAGS; q++) begin : g_flag
      qsr_flag_bit u_bit (
        .clk      (clk),
        .rst      (rst),
        .set_i    (set_vec[q]),
        .arm_ld_i (stat_rd),
        .wr_i     (stat_wr),
        .wbit_i   (bus_wdata[q]),
        .flag_o   (flags[q])
      );
    end
  endgenerate

  qsr_irq_gen #(.NUM_Q(NUM_Q)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .done_i  (done_f),
    .pause_i (pause_f),
    .cie_i   (cie),
    .pie_i   (pie),
    .irq_o   (irq)
  );

  always_comb begin
    stat_word = '0;
    stat_word[NUM_FLAGS-1:0] = flags;
    stat_word[DATA_W-1 -: VIEW_W] = seq_view;
  end

  always_comb begin
    rd_next = '0;
    if (bus_addr == STAT_ADDR)
      rd_next = stat_word;
    else
      for (int i = 0; i < NUM_Q; i++)
        if (bus_addr == ADDR_W'(i)) rd_next = ctrl_word[i];
  end

  always_ff @(posedge clk) begin
    if (rst)                  bus_rdata <= '0;
    else if (bus_rd && !bus_wr) bus_rdata <= rd_next;
  end
endmodule

// File: rtl/qsr_checker.sv
module qsr_checker #(
  parameter int NUM_Q  = 2,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 bus_wr,
  input logic                 bus_rd,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [DATA_W-1:0]    bus_wdata,
  input logic [DATA_W-1:0]    bus_rdata,
  input logic [NUM_Q-1:0]     ev_done,
  input logic [NUM_Q-1:0]     ev_trig_ovr,
  input logic [3*NUM_Q-1:0]   flags,
  input logic [NUM_Q-1:0]     scan_start,
  input logic [NUM_Q-1:0]     irq
);
  logic st_wr;
  assign st_wr = bus_wr && (bus_addr == ADDR_W'(NUM_Q));

  genvar i;
  generate
    for (i = 0; i < 3*NUM_Q; i++) begin : g_fl
      // R3 / R4: a flag only falls after a status write carrying a zero there.
      assert_clear_by_write_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(flags[i]) |-> $past(st_wr && !bus_wdata[i]));
    end
    for (i = 0; i < NUM_Q; i++) begin : g_q
      assert_done_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
        ev_done[i] |=> flags[2*i]);
      assert_ovr_sets_R2: assert property (@(posedge clk) disable iff (rst)
        ev_trig_ovr[i] |=> flags[2*NUM_Q + i]);
      assert_start_from_write_R10: assert property (@(posedge clk) disable iff (rst)
        scan_start[i] |-> $past(bus_wr && bus_addr == ADDR_W'(i) && bus_wdata[0]));
      assert_irq_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        (!flags[2*i] && !flags[2*i+1]) |=> !irq[i]);
    end
  endgenerate

  assert_sse_reads_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr && bus_addr < ADDR_W'(NUM_Q)) |=> !bus_rdata[0]);
  assert_unmapped_zero_R12: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr && bus_addr > ADDR_W'(NUM_Q)) |=> bus_rdata == '0);
endmodule

bind qseq_status_regs qsr_checker #(
  .NUM_Q(NUM_Q), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_qsr_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_done(ev_done),
  .ev_trig_ovr(ev_trig_ovr), .flags(flags), .scan_start(scan_start), .irq(irq)
);

// File: tb/tb_qseq_status_regs.sv
module tb_qseq_status_regs;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] ST = 4'd2;

  logic        clk = 0, rst = 1, bus_wr = 0, bus_rd = 0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic [1:0]  ev_done = 0, ev_pause = 0, ev_trig_ovr = 0;
  logic [7:0]  seq_view = 8'hA5;
  logic [3:0]  q_mode;
  logic [1:0]  scan_start, irq;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qseq_status_regs dut (.*);

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic ev(input int kind, input int q);
    case (kind)
      0: ev_done[q] = 1;
      1: ev_pause[q] = 1;
      default: ev_trig_ovr[q] = 1;
    endcase
    @(negedge clk); ev_done = 0; ev_pause = 0; ev_trig_ovr = 0;
  endtask

  task automatic clear_all();
    logic [15:0] d;
    rd(ST, d); wr(ST, 16'h0000);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(ST, d);  chk("R1 status after reset", d, 16'hA500);
    rd(4'd0, d); chk("R1 ctrl0 after reset", d, 16'h0000);
    chk("R1 irq/start after reset", {12'h0, irq, scan_start}, 16'h0000);
  endtask

  task automatic t_set_clear();
    logic [15:0] d;
    ev(0, 0); ev(2, 1);
    rd(ST, d); chk("R2 done0 and ovr1 set", d, 16'hA521);
    wr(ST, 16'h0000);
    rd(ST, d); chk("R3 armed bits cleared by zero write", d, 16'hA500);
  endtask

  task automatic t_one_keeps_and_drop();
    logic [15:0] d;
    ev(1, 1);
    rd(ST, d); wr(ST, 16'hFFFF);
    rd(ST, d); chk("R3 writing one keeps flag", d, 16'hA508);
    // that read re-armed; write one again to drop arms, then zero
    wr(ST, 16'hFFFF); wr(ST, 16'h0000);
    rd(ST, d); chk("R6 arm dropped after write", d, 16'hA508);
    clear_all();
  endtask

  task automatic t_no_read();
    logic [15:0] d;
    ev(0, 1);
    wr(ST, 16'h0000);
    rd(ST, d); chk("R4 zero write without read", d, 16'hA504);
    clear_all();
  endtask

  task automatic t_late_set();
    logic [15:0] d;
    ev(0, 0);
    rd(ST, d);
    ev(1, 0);
    wr(ST, 16'h0000);
    rd(ST, d); chk("R5 late flag survives, armed flag clears", d, 16'hA502);
    clear_all();
  endtask

  task automatic t_set_wins();
    logic [15:0] d;
    ev(0, 0);
    rd(ST, d);
    ev_done[0] = 1; bus_wr = 1; bus_addr = ST; bus_wdata = 16'h0000;
    @(negedge clk); bus_wr = 0; ev_done = 0;
    rd(ST, d); chk("R7 set wins over clear", d, 16'hA501);
    clear_all();
  endtask

  task automatic t_view();
    logic [15:0] d;
    seq_view = 8'h3C;
    wr(ST, 16'h00C0);
    rd(ST, d); chk("R8 view follows input, bits 7:6 zero", d, 16'h3C00);
    seq_view = 8'hA5;
  endtask

  task automatic t_start();
    wr(4'd0, 16'h0001);
    chk("R10 start pulse queue0", {14'h0, scan_start}, 16'h0001);
    @(negedge clk);
    chk("R10 start pulse ends", {14'h0, scan_start}, 16'h0000);
    wr(4'd1, 16'h0000);
    chk("R10 no pulse on zero", {14'h0, scan_start}, 16'h0000);
  endtask

  task automatic t_ctrl();
    logic [15:0] d;
    wr(4'd0, 16'h001F);
    rd(4'd0, d); chk("R9 ctrl0 readback, strobe zero", d, 16'h001E);
    wr(4'd1, 16'h000A);
    rd(4'd1, d); chk("R9 ctrl1 readback", d, 16'h000A);
    chk("R9 q_mode", {12'h0, q_mode}, 16'h0007);
  endtask

  task automatic t_irq();
    logic [15:0] d;
    wr(4'd0, 16'h0008); wr(4'd1, 16'h0010);
    ev(1, 0); @(negedge clk);
    chk("R11 pause0 masked", {14'h0, irq}, 16'h0000);
    ev(0, 0);
    chk("R11 irq not yet", {14'h0, irq}, 16'h0000);
    @(negedge clk);
    chk("R11 irq0 from done0", {14'h0, irq}, 16'h0001);
    ev(1, 1); @(negedge clk);
    chk("R11 irq1 from pause1", {14'h0, irq}, 16'h0003);
    clear_all(); @(negedge clk);
    chk("R11 irq drops after clear", {14'h0, irq}, 16'h0000);
    rd(ST, d); chk("R3 all cleared", d, 16'hA500);
  endtask

  task automatic t_unmapped();
    logic [15:0] d;
    rd(4'd7, d); chk("R12 unmapped reads zero", d, 16'h0000);
    rd(ST, d);   chk("R12 status read data", d, 16'hA500);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset(); t_set_clear(); t_one_keeps_and_drop(); t_no_read();
        t_late_set(); t_set_wins(); t_view(); t_start(); t_ctrl();
        t_irq(); t_unmapped();
      end
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule